// File: doc/BRIEF.md
# Serial DAC Command Frame Sequencer

This block is a serial-bus master that updates one channel of a four-channel 12-bit serial DAC. A one-cycle start pulse latches a 4-bit channel address and a 12-bit code. The block builds a padded 32-bit write-and-update command and shifts it out MSB first. At the same time it shifts in the 32 bits the converter returns. The converter's internal 32-bit shift register echoes the word it held before, so the captured bits are the command from the previous frame.

The serial clock idles low. Each bit is driven while the clock is low, and the return line is sampled in the last system cycle of the high phase. That sample lands on the same edge at which the clock falls, which gives the slow converter output the most time to settle. The converter select stays low for the whole frame. It rises half a bit period after the last falling edge, and that rising edge makes the converter execute the command. One cycle later a done pulse marks that the readback word is valid.

The block holds the other select and control lines of the shared bus at their inactive levels. A separate request produces a short active-low pulse on the converter clear line.

Top module: `dac_frame_seq`

## Requirements
- R1: A frame carries 32 bits, MSB first: bits 31..24 are zero, bits 23..20 are the command 4'b0011, bits 19..16 are the channel address (0..3 for single channels, 4'hF for all channels, passed through unchanged), bits 15..4 are the code MSB first, and bits 3..0 are zero.
- R2: Each frame produces exactly 32 rising edges of sck_o.
- R3: sck_o is low outside a frame. mosi_o changes only while sck_o is low. miso_i is sampled on the system edge that ends each high phase.
- R4: dac_cs_no is low for the whole frame and never high while sck_o is high. It rises HALF_CYC cycles after the last falling edge of sck_o.
- R5: readback_o presents the 32 bits sampled from miso_i, first sample in bit 31. With a converter that echoes its previous command, this equals the command of the previous frame.
- R6: At reset and idle, the lines take these levels: sck_o 0, dac_cs_no 1, dac_clr_no 1, rom_cs_no 1, spare_o 1, amp_cs_no 1, adc_conv_o 0, amp_shdn_o 0. busy_o, done_o and readback_o are 0 after reset.
- R7: A clr_req_i pulse drives dac_clr_no low for CLR_CYC cycles, starting the cycle after the request. A request made while the pulse is active does not lengthen it.
- R8: Every high phase and every low phase of sck_o inside a frame lasts HALF_CYC system cycles (default 10, giving 20 cycles per bit).
- R9: busy_o is high from the cycle after an accepted start until the done cycle. A start pulse while busy is ignored: it does not change the frame in progress and does not start another frame.
- R10: done_o is a one-cycle pulse, 2*32*HALF_CYC+HALF_CYC+1 cycles after the start edge (651 by default). It comes one cycle after dac_cs_no rises, and readback_o updates in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle request to send a frame |
| addr_i | input | 4 | Channel address |
| code_i | input | 12 | Output code |
| clr_req_i | input | 1 | Request for a clear pulse |
| miso_i | input | 1 | Serial data returned by the converter |
| sck_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data to the converter |
| dac_cs_no | output | 1 | Converter select, active low |
| dac_clr_no | output | 1 | Converter clear, active low |
| rom_cs_no | output | 1 | Flash select held inactive |
| spare_o | output | 1 | Spare control held high |
| amp_cs_no | output | 1 | Amplifier select held inactive |
| adc_conv_o | output | 1 | ADC convert held low |
| amp_shdn_o | output | 1 | Amplifier shutdown held low |
| busy_o | output | 1 | Frame in progress |
| done_o | output | 1 | Frame finished, readback valid |
| readback_o | output | 32 | Word shifted in during the last frame |

## Verification
A behavioural converter model in the bench shifts in mosi_o on rising edges of sck_o and shifts out its previous word on falling edges. It starts from a nonzero seed word. Each frame's captured command is then compared with a field-by-field computed frame, which exposes errors in field order, padding or bit order. Each readback is compared with the previous frame's command, which separates a correct sample point and bit order from shifted or reversed capture.

Directed frames cover all-ones, all-zeros, the broadcast address and a mid-scale code. Random address and code pairs fill in the rest. A start injected mid-frame with different data must leave the frame, its latency and the idle bus afterwards unchanged. Clear requests are tried alone and again while a pulse is already active.

// File: rtl/dac_seq_pkg.sv
package dac_seq_pkg;
  localparam int FRAME_W = 32;
  localparam int CODE_W  = 12;
  localparam int ADDR_W  = 4;
  localparam int CMD_W   = 4;
  localparam int PAD_HI  = 8;
  localparam int PAD_LO  = FRAME_W - PAD_HI - CMD_W - ADDR_W - CODE_W;

  localparam logic [CMD_W-1:0] CMD_WR_UPD = 4'b0011;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOW,
    ST_HIGH,
    ST_TAIL,
    ST_REL
  } seq_state_e;

  function automatic logic [FRAME_W-1:0] build_frame(input logic [ADDR_W-1:0] addr,
                                                     input logic [CODE_W-1:0] code);
    return {{PAD_HI{1'b0}}, CMD_WR_UPD, addr, code, {PAD_LO{1'b0}}};
  endfunction
endpackage

// File: rtl/dac_phase_timer.sv
module dac_phase_timer #(
  parameter int HALF_CYC = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic last_o
);
  localparam int CW = $clog2(HALF_CYC + 1);

  logic [CW-1:0] cnt_q;

  assign last_o = run_i && (cnt_q == CW'(HALF_CYC - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (!run_i) cnt_q <= '0;
    else if (last_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  // R8
  ph_reset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (cnt_q == '0));
endmodule

// File: rtl/dac_shift_core.sv
module dac_shift_core #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] frame_i,
  input  logic         shift_i,
  input  logic         miso_i,
  output logic         mosi_o,
  output logic [W-1:0] rx_o
);
  logic [W-1:0] tx_q, rx_q;

  assign mosi_o = tx_q[W-1];
  assign rx_o   = rx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_q <= '0;
      rx_q <= '0;
    end else if (load_i) begin
      tx_q <= frame_i;
      rx_q <= '0;
    end else if (shift_i) begin
      tx_q <= {tx_q[W-2:0], 1'b0};
      rx_q <= {rx_q[W-2:0], miso_i};
    end
  end

  // R3
  tx_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !shift_i) |=> $stable(mosi_o));
endmodule

// File: rtl/dac_clr_pulse.sv
module dac_clr_pulse #(
  parameter int CLR_CYC = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  output logic clr_no
);
  localparam int CW = $clog2(CLR_CYC + 1);

  logic [CW-1:0] cnt_q;

  assign clr_no = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_q <= '0;
    else if (cnt_q != '0)          cnt_q <= cnt_q - 1'b1;
    else if (req_i)                cnt_q <= CW'(CLR_CYC);
  end

  // R7
  clr_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && clr_no) |=> !clr_no);

  generate
    if (CLR_CYC > 1) begin : g_hold
      // R7
      clr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(clr_no) |=> !clr_no);
    end
  endgenerate
endmodule

// File: rtl/dac_frame_seq.sv
module dac_frame_seq
  import dac_seq_pkg::*;
#(
  parameter int HALF_CYC = 10,
  parameter int CLR_CYC  = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [CODE_W-1:0]  code_i,
  input  logic               clr_req_i,
  input  logic               miso_i,
  output logic               sck_o,
  output logic               mosi_o,
  output logic               dac_cs_no,
  output logic               dac_clr_no,
  output logic               rom_cs_no,
  output logic               spare_o,
  output logic               amp_cs_no,
  output logic               adc_conv_o,
  output logic               amp_shdn_o,
  output logic               busy_o,
  output logic               done_o,
  output logic [FRAME_W-1:0] readback_o
);
  localparam int BIT_W = $clog2(FRAME_W);

  seq_state_e         state_q, state_d;
  logic [BIT_W-1:0]   bit_q;
  logic               run, ph_last, load, shift, last_bit;
  logic [FRAME_W-1:0] rx_word;
  logic               done_q;
  logic [FRAME_W-1:0] rb_q;

  // Other devices on the shared bus stay parked.
  assign rom_cs_no  = 1'b1;
  assign spare_o    = 1'b1;
  assign amp_cs_no  = 1'b1;
  assign adc_conv_o = 1'b0;
  assign amp_shdn_o = 1'b0;

  assign run      = (state_q == ST_LOW) || (state_q == ST_HIGH) || (state_q == ST_TAIL);
  assign load     = (state_q == ST_IDLE) && start_i;
  assign shift    = (state_q == ST_HIGH) && ph_last;
  assign last_bit = (bit_q == BIT_W'(FRAME_W - 1));

  assign sck_o      = (state_q == ST_HIGH);
  assign dac_cs_no  = (state_q == ST_IDLE) || (state_q == ST_REL);
  assign busy_o     = (state_q != ST_IDLE);
  assign done_o     = done_q;
  assign readback_o = rb_q;

  dac_phase_timer #(.HALF_CYC(HALF_CYC)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run),
    .last_o (ph_last)
  );

  dac_shift_core #(.W(FRAME_W)) u_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load),
    .frame_i (build_frame(addr_i, code_i)),
    .shift_i (shift),
    .miso_i  (miso_i),
    .mosi_o  (mosi_o),
    .rx_o    (rx_word)
  );

  dac_clr_pulse #(.CLR_CYC(CLR_CYC)) u_clr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (clr_req_i),
    .clr_no (dac_clr_no)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start_i) state_d = ST_LOW;
      ST_LOW:  if (ph_last) state_d = ST_HIGH;
      ST_HIGH: if (ph_last) state_d = last_bit ? ST_TAIL : ST_LOW;
      ST_TAIL: if (ph_last) state_d = ST_REL;
      ST_REL:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      bit_q   <= '0;
      done_q  <= 1'b0;
      rb_q    <= '0;
    end else begin
      state_q <= state_d;
      done_q  <= (state_q == ST_REL);
      if (load)                 bit_q <= '0;
      else if (shift)           bit_q <= bit_q + 1'b1;
      if (state_q == ST_REL)    rb_q  <= rx_word;
    end
  end

  // R4
  sck_cs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sck_o |-> !dac_cs_no);

  // R3
  mosi_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sck_o && $past(sck_o)) |-> $stable(mosi_o));

  // R10
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R10
  done_after_cs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (dac_cs_no && $past(dac_cs_no) && !$past(done_o)));

  // R9
  busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i && state_q != ST_REL) |=> busy_o);

  // R10
  rb_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(readback_o));
endmodule

// File: tb/dac_frame_seq_tb.sv
module dac_frame_seq_tb;
  localparam int HALF = 10;
  localparam int CLRC = 4;
  localparam int LAT  = 2 * 32 * HALF + HALF + 1;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic start_i = 1'b0, clr_req_i = 1'b0;
  logic [3:0] addr_i = '0;
  logic [11:0] code_i = '0;
  logic miso_i;
  logic sck_o, mosi_o, dac_cs_no, dac_clr_no, rom_cs_no, spare_o, amp_cs_no;
  logic adc_conv_o, amp_shdn_o, busy_o, done_o;
  logic [31:0] readback_o;

  int nchk = 0, nerr = 0;

  always #2 clk_i = ~clk_i;

  dac_frame_seq #(.HALF_CYC(HALF), .CLR_CYC(CLRC)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .addr_i(addr_i),
    .code_i(code_i), .clr_req_i(clr_req_i), .miso_i(miso_i), .sck_o(sck_o),
    .mosi_o(mosi_o), .dac_cs_no(dac_cs_no), .dac_clr_no(dac_clr_no),
    .rom_cs_no(rom_cs_no), .spare_o(spare_o), .amp_cs_no(amp_cs_no),
    .adc_conv_o(adc_conv_o), .amp_shdn_o(amp_shdn_o), .busy_o(busy_o),
    .done_o(done_o), .readback_o(readback_o)
  );

  // Converter model: shift in on rise, shift out on fall, execute on select release.
  logic [31:0] sr = 32'hC3A5_5A3C;
  logic [31:0] exec_cmd = '0;
  logic in_bit = 1'b0;
  int rises = 0;
  assign miso_i = sr[31];
  always @(posedge sck_o) begin in_bit = mosi_o; rises++; end
  always @(negedge sck_o) sr = {sr[30:0], in_bit};
  always @(posedge dac_cs_no) exec_cmd = sr;

  // Line monitor sampled between edges.
  int mon_err = 0, width_err = 0, hi_run = 0, lo_run = 0;
  logic p_sck = 1'b0, p_mosi = 1'b0;
  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (sck_o && dac_cs_no) mon_err++;
      if (sck_o && p_sck && (mosi_o != p_mosi)) mon_err++;
      if (sck_o) begin
        if (!p_sck && lo_run != HALF) width_err++;
        hi_run++; lo_run = 0;
      end else begin
        if (p_sck && hi_run != HALF) width_err++;
        hi_run = 0;
        if (!dac_cs_no) lo_run++; else lo_run = 0;
      end
    end
    p_sck = sck_o; p_mosi = mosi_o;
  end

  function automatic logic [31:0] exp_frame(input logic [3:0] a, input logic [11:0] c);
    return {8'h00, 4'b0011, a, c, 4'h0};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  logic [31:0] prev_cmd = 32'hC3A5_5A3C;

  task automatic run_frame(input logic [3:0] a, input logic [11:0] c, input bit inject);
    int lat, busy_low, r0, me0, we0, cs_low;
    logic [31:0] exp;
    exp = exp_frame(a, c);
    r0 = rises; me0 = mon_err; we0 = width_err;
    @(negedge clk_i);
    start_i = 1'b1; addr_i = a; code_i = c;
    @(posedge clk_i);
    lat = 0; busy_low = 0;
    forever begin
      @(negedge clk_i);
      start_i = 1'b0;
      if (inject && lat == 100) begin
        start_i = 1'b1; addr_i = ~a; code_i = ~c;
      end
      if (done_o || lat > 2000) break;
      if (!busy_o) busy_low++;
      @(posedge clk_i);
      lat++;
    end
    start_i = 1'b0;
    chk(lat == LAT, "R10 latency", lat, LAT);
    chk(!busy_o, "R9 busy clear at done", {31'b0, busy_o}, 0);
    chk(busy_low == 0, "R9 busy through frame", busy_low, 0);
    chk(rises - r0 == 32, "R2 sck rises", rises - r0, 32);
    chk(exec_cmd == exp, "R1 frame", exec_cmd, exp);
    chk(readback_o == prev_cmd, "R5 readback", readback_o, prev_cmd);
    chk(mon_err == me0, "R3 R4 line order", mon_err - me0, 0);
    chk(width_err == we0, "R8 phase width", width_err - we0, 0);
    @(posedge clk_i);
    @(negedge clk_i);
    chk(!done_o, "R10 done one cycle", {31'b0, done_o}, 0);
    if (inject) begin
      cs_low = 0;
      repeat (30) begin
        @(negedge clk_i);
        if (!dac_cs_no || busy_o) cs_low++;
      end
      chk(cs_low == 0, "R9 ignored start", cs_low, 0);
    end
    prev_cmd = exp;
  endtask

  task automatic clr_test(input bit second);
    int low_cnt;
    @(negedge clk_i);
    clr_req_i = 1'b1;
    @(posedge clk_i);
    low_cnt = 0;
    repeat (CLRC + 4) begin
      @(negedge clk_i);
      clr_req_i = second && (low_cnt == 1);
      if (!dac_clr_no) low_cnt++;
      @(posedge clk_i);
    end
    clr_req_i = 1'b0;
    chk(low_cnt == CLRC, "R7 clear width", low_cnt, CLRC);
  endtask

  task automatic summary;
    $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    nchk++; nerr++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'd4242);
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    @(negedge clk_i);
    // R6
    chk({sck_o, dac_cs_no, dac_clr_no, rom_cs_no, spare_o, amp_cs_no, adc_conv_o,
         amp_shdn_o, busy_o, done_o} == 10'b0111110000, "R6 idle levels",
        {22'b0, sck_o, dac_cs_no, dac_clr_no, rom_cs_no, spare_o, amp_cs_no,
         adc_conv_o, amp_shdn_o, busy_o, done_o}, 32'h1F0);
    chk(readback_o == 0, "R6 readback reset", readback_o, 0);

    run_frame(4'hF, 12'hFFF, 1'b0);
    run_frame(4'h0, 12'h000, 1'b0);
    run_frame(4'h2, 12'h800, 1'b0);
    run_frame(4'h1, 12'h5A5, 1'b1);
    for (int i = 0; i < 18; i++) begin
      logic [3:0] a;
      logic [11:0] c;
      a = 4'($urandom_range(0, 3));
      if (($urandom() & 32'h7) == 0) a = 4'hF;
      c = 12'($urandom());
      run_frame(a, c, ($urandom() & 32'h3) == 0);
    end

    clr_test(1'b0);
    clr_test(1'b1);

    @(negedge clk_i);
    // R6
    chk({sck_o, dac_cs_no, rom_cs_no, spare_o, amp_cs_no, adc_conv_o, amp_shdn_o}
        == 7'b0111100, "R6 idle after traffic",
        {25'b0, sck_o, dac_cs_no, rom_cs_no, spare_o, amp_cs_no, adc_conv_o, amp_shdn_o},
        32'h3C);
    summary();
    $finish;
  end
endmodule